// File: doc/BRIEF.md
# Two-Class Output Link Arbiter

This block sits at one output port of an on-chip router and shares a single outgoing link between two traffic classes. Packets arrive on several valid/ready ingress streams as head, body and tail flits. Only the head flit carries a class bit, which the sending endpoint sets. The block reads that bit and places the whole packet in one of two small queues. One queue holds guaranteed-service traffic and the other holds best-effort traffic.

An arbiter in front of the link always gives guaranteed traffic first claim. Best-effort flits use only the link cycles that guaranteed traffic leaves idle, and they get no bandwidth promise. Packets never interleave. Once a packet's head is offered on the link, the link stays with that class until the packet's tail has been accepted. This holds even if the other queue fills in the meantime. A best-effort packet that has started therefore delays a new guaranteed head by at most the rest of that packet. Downstream back-pressure is handled with valid/ready, so no flit is ever dropped. Each queue reports its fill level.

Top module: `gsbe_link_arb`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` is low and both `gs_count` and `be_count` are zero.
- R2: A flit is `{head, tail, payload}`: bit DATA_W+1 is head, bit DATA_W is tail, a single-flit packet has both set, and a body flit has neither. On a head flit, payload bit 0 selects the class: 1 is guaranteed service and 0 is best effort. Body and tail flits follow the class of the last head accepted on the same ingress port.
- R3: Each queue holds DEPTH (default 4) flits. `gs_count` and `be_count` equal the number of flits held. While a queue is full, an ingress port whose flit is aimed at that queue sees `in_ready` low.
- R4: When no packet is committed to the link and the guaranteed queue holds a flit, the link offers the front of the guaranteed queue.
- R5: Once a head flit is offered, the link serves only that head's class until that packet's tail is accepted. A best-effort packet in progress completes before guaranteed traffic is served. If the committed queue runs dry mid-packet, `out_valid` drops rather than switching class.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_flit` is unchanged. Each class delivers its flits in arrival order, with none lost or repeated.
- R7: An ingress port that writes a multi-flit head into a queue owns that queue's write side until it writes the tail. Heads from other ports aimed at that queue see `in_ready` low. When several heads aim at a free queue in the same cycle, the lowest-numbered port wins.
- R8: When no packet is committed, the guaranteed queue is empty and the best-effort queue holds a flit, the link offers the front of the best-effort queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NPORT | Per-port flit valid |
| in_flit | input | NPORT x (DATA_W+2) | Per-port flit `{head, tail, payload}` |
| in_ready | output | NPORT | Per-port flit accepted this cycle when valid |
| out_valid | output | 1 | Link flit valid |
| out_flit | output | DATA_W+2 | Link flit |
| out_ready | input | 1 | Downstream accepts the link flit |
| gs_count | output | $clog2(DEPTH+1) | Flits held in the guaranteed queue |
| be_count | output | $clog2(DEPTH+1) | Flits held in the best-effort queue |

## Verification
A wrong class latch or write lock shows up at the ports as a count that rises in the wrong queue, or as `in_ready` differing from the expected value, in the same cycle as the flit it affects. A wrong commit state shows up as `out_valid` or `out_flit` coming from the wrong queue. That happens either at the first offer after a tail or while a guaranteed head waits behind a best-effort packet. The bench's reference model predicts every port in every cycle, so any such divergence is reported in the cycle it first appears. This is checked under heavy contention, long downstream stalls and mid-packet class changes of the other queue.

// File: rtl/gsbe_pkg.sv
package gsbe_pkg;

    typedef enum logic {
        CLS_BE = 1'b0,
        CLS_GS = 1'b1
    } cls_e;

    localparam int NCLS = 2;

    // Reads the flag bits of a flit of width fw = payload + 2
    function automatic logic flit_is_head(input logic [1:0] flags);
        return flags[1];
    endfunction

    function automatic logic flit_is_tail(input logic [1:0] flags);
        return flags[0];
    endfunction

endpackage

// File: rtl/gsbe_fifo.sv
module gsbe_fifo #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             nempty,
    output logic [CW-1:0]    count
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] ptr);
        return (ptr == AW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
    endfunction

    assign full   = (count == CW'(DEPTH));
    assign nempty = (count != '0);
    assign rdata  = mem[rptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) begin
                mem[wptr] <= wdata;
                wptr      <= bump(wptr);
            end
            if (pop) rptr <= bump(rptr);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) push |-> !full); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) pop |-> nempty); // R6

endmodule

// File: rtl/gsbe_ingress.sv
module gsbe_ingress (
    input  logic clk,
    input  logic rst,
    input  logic is_head,
    input  logic cls_bit,
    input  logic fire,
    output logic tgt
);

    logic cls_q;

    // A head steers by its own bit; later flits follow the latched class
    assign tgt = is_head ? cls_bit : cls_q;

    always_ff @(posedge clk) begin
        if (rst)                  cls_q <= 1'b0;
        else if (fire && is_head) cls_q <= cls_bit;
    end

endmodule

// File: rtl/gsbe_egress.sv
module gsbe_egress
    import gsbe_pkg::*;
#(
    parameter int FLIT_W = 18
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NCLS-1:0]               q_nempty,
    input  logic [NCLS-1:0][FLIT_W-1:0]   q_front,
    input  logic                          out_ready,
    output logic                          out_valid,
    output logic [FLIT_W-1:0]             out_flit,
    output logic [NCLS-1:0]               q_pop
);

    logic cmt_on;
    cls_e cmt_cls;
    cls_e sel;
    logic fire, tail;

    always_comb begin
        if (cmt_on)                 sel = cmt_cls;
        else if (q_nempty[CLS_GS])  sel = CLS_GS;
        else                        sel = CLS_BE;
    end

    assign out_valid = q_nempty[sel];
    assign out_flit  = q_front[sel];
    assign fire      = out_valid && out_ready;
    assign tail      = flit_is_tail(out_flit[FLIT_W-1 -: 2]);

    always_comb begin
        q_pop = '0;
        q_pop[sel] = fire;
    end

    // Commit on first offer, release on accepted tail
    always_ff @(posedge clk) begin
        if (rst) begin
            cmt_on  <= 1'b0;
            cmt_cls <= CLS_BE;
        end else if (fire && tail) begin
            cmt_on  <= 1'b0;
        end else if (out_valid) begin
            cmt_on  <= 1'b1;
            cmt_cls <= sel;
        end
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_flit))); // R6

endmodule

// File: rtl/gsbe_link_arb.sv
module gsbe_link_arb
    import gsbe_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    parameter int NPORT  = 2,
    localparam int FLIT_W = DATA_W + 2,
    localparam int CW     = $clog2(DEPTH + 1),
    localparam int PW     = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NPORT-1:0]              in_valid,
    input  logic [NPORT-1:0][FLIT_W-1:0]  in_flit,
    output logic [NPORT-1:0]              in_ready,
    output logic                          out_valid,
    output logic [FLIT_W-1:0]             out_flit,
    input  logic                          out_ready,
    output logic [CW-1:0]                 gs_count,
    output logic [CW-1:0]                 be_count
);

    logic [NPORT-1:0] hd, tl, tgt, fire;
    logic [NCLS-1:0][NPORT-1:0] claim, win, fire_to;
    logic [NCLS-1:0]             lock_on, q_full, q_nempty, q_pop, wr_en;
    logic [NCLS-1:0][PW-1:0]     lock_by, wr_port;
    logic [NCLS-1:0][FLIT_W-1:0] wr_data, q_front;
    logic [NCLS-1:0][CW-1:0]     q_count;

    // Per-port class steering
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign hd[p] = flit_is_head(in_flit[p][FLIT_W-1 -: 2]);
        assign tl[p] = flit_is_tail(in_flit[p][FLIT_W-1 -: 2]);
        gsbe_ingress u_ing (
            .clk     (clk),
            .rst     (rst),
            .is_head (hd[p]),
            .cls_bit (in_flit[p][0]),
            .fire    (fire[p]),
            .tgt     (tgt[p])
        );
    end

    // Heads contending for a free queue: lowest port index wins
    always_comb begin
        for (int q = 0; q < NCLS; q++) begin
            logic taken;
            taken = 1'b0;
            for (int p = 0; p < NPORT; p++) begin
                claim[q][p] = in_valid[p] && hd[p] && (tgt[p] == 1'(q)) && !lock_on[q];
                win[q][p]   = claim[q][p] && !taken;
                taken       = taken || claim[q][p];
            end
        end
    end

    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            logic allow;
            if (lock_on[tgt[p]]) allow = (lock_by[tgt[p]] == PW'(p));
            else                 allow = win[tgt[p]][p];
            in_ready[p] = allow && !q_full[tgt[p]];
            fire[p]     = in_valid[p] && in_ready[p];
        end
    end

    // Write side of each queue, with per-queue ownership lock
    for (genvar q = 0; q < NCLS; q++) begin : g_cls
        always_comb begin
            wr_port[q] = '0;
            for (int p = 0; p < NPORT; p++) begin
                fire_to[q][p] = fire[p] && (tgt[p] == 1'(q));
                if (fire_to[q][p]) wr_port[q] = PW'(p);
            end
            wr_en[q]   = |fire_to[q];
            wr_data[q] = in_flit[wr_port[q]];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                lock_on[q] <= 1'b0;
                lock_by[q] <= '0;
            end else if (wr_en[q]) begin
                if (hd[wr_port[q]] && !tl[wr_port[q]]) begin
                    lock_on[q] <= 1'b1;
                    lock_by[q] <= wr_port[q];
                end else if (tl[wr_port[q]]) begin
                    lock_on[q] <= 1'b0;
                end
            end
        end

        gsbe_fifo #(.WIDTH(FLIT_W), .DEPTH(DEPTH)) u_q (
            .clk    (clk),
            .rst    (rst),
            .push   (wr_en[q]),
            .wdata  (wr_data[q]),
            .pop    (q_pop[q]),
            .rdata  (q_front[q]),
            .full   (q_full[q]),
            .nempty (q_nempty[q]),
            .count  (q_count[q])
        );

        AST_ONE_WRITER: assert property (@(posedge clk) disable iff (rst) $onehot0(fire_to[q])); // R7
    end

    gsbe_egress #(.FLIT_W(FLIT_W)) u_egr (
        .clk       (clk),
        .rst       (rst),
        .q_nempty  (q_nempty),
        .q_front   (q_front),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_flit  (out_flit),
        .q_pop     (q_pop)
    );

    assign gs_count = q_count[CLS_GS];
    assign be_count = q_count[CLS_BE];

    // Packet-level tracking on the link, for the interleave check
    logic out_open;
    logic out_cls;
    logic out_fire;
    assign out_fire = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_open <= 1'b0;
            out_cls  <= 1'b0;
        end else if (out_fire) begin
            if (flit_is_head(out_flit[FLIT_W-1 -: 2]) && !flit_is_tail(out_flit[FLIT_W-1 -: 2])) begin
                out_open <= 1'b1;
                out_cls  <= q_pop[CLS_GS];
            end else if (flit_is_tail(out_flit[FLIT_W-1 -: 2])) begin
                out_open <= 1'b0;
            end
        end
    end

    AST_PKT_ATOMIC: assert property (@(posedge clk) disable iff (rst)
        (out_open && out_fire) |-> q_pop[out_cls]); // R5

endmodule

// File: tb/tb_gsbe_link_arb.sv
module tb_gsbe_link_arb;

    localparam int CLK_PERIOD = 10;
    localparam int DW    = 16;
    localparam int DEPTH = 4;
    localparam int NP    = 2;
    localparam int FW    = DW + 2;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int NCYC  = 5600;

    logic                clk = 1'b0;
    logic                rst;
    logic [NP-1:0]       in_valid;
    logic [NP-1:0][FW-1:0] in_flit;
    logic [NP-1:0]       in_ready;
    logic                out_valid;
    logic [FW-1:0]       out_flit;
    logic                out_ready;
    logic [CW-1:0]       gs_count, be_count;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gsbe_link_arb #(.DATA_W(DW), .DEPTH(DEPTH), .NPORT(NP)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_flit(in_flit),
        .in_ready(in_ready), .out_valid(out_valid), .out_flit(out_flit),
        .out_ready(out_ready), .gs_count(gs_count), .be_count(be_count)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference model state: queues index 1 = guaranteed, 0 = best effort
    logic [FW-1:0] mq [2][$];
    bit  lk_on [2];
    int  lk_by [2];
    int  pcls  [NP];
    bit  c_on;
    int  c_cls;

    // Stimulus state
    logic [FW-1:0] pend [NP][$];
    bit  cur_v [NP];
    int  seq   [NP];

    // Expected combinational values
    bit e_rdy [NP];
    int e_tgt [NP];
    bit e_ov;
    int e_sel;

    function automatic bit fhead(logic [FW-1:0] f); return f[FW-1]; endfunction
    function automatic bit ftail(logic [FW-1:0] f); return f[FW-2]; endfunction

    task automatic make_pkt(input int p, input int cls, input int len);
        for (int i = 0; i < len; i++) begin
            logic [DW-1:0] pl;
            pl = {1'(p), 8'(seq[p]), 3'(i), 3'($urandom), 1'($urandom)};
            if (i == 0) pl[0] = 1'(cls);
            pend[p].push_back({1'(i == 0), 1'(i == len - 1), pl});
        end
        seq[p]++;
    endtask

    task automatic model_comb();
        bit taken [2];
        taken[0] = 0; taken[1] = 0;
        for (int p = 0; p < NP; p++) begin
            logic [FW-1:0] f;
            bit ok;
            f = cur_v[p] ? pend[p][0] : '0;
            e_tgt[p] = fhead(f) ? int'(f[0]) : pcls[p];
            if (lk_on[e_tgt[p]]) ok = (lk_by[e_tgt[p]] == p);
            else begin
                ok = cur_v[p] && fhead(f) && !taken[e_tgt[p]];
                if (cur_v[p] && fhead(f)) taken[e_tgt[p]] = 1;
            end
            e_rdy[p] = ok && (mq[e_tgt[p]].size() < DEPTH);
        end
        if (c_on)                    e_sel = c_cls;
        else if (mq[1].size() > 0)   e_sel = 1;
        else                         e_sel = 0;
        e_ov = (mq[e_sel].size() > 0);
    endtask

    task automatic model_step();
        if (e_ov && out_ready) begin
            logic [FW-1:0] f;
            f = mq[e_sel].pop_front();
            if (ftail(f)) c_on = 0;
            else begin c_on = 1; c_cls = e_sel; end
        end else if (e_ov) begin
            c_on = 1; c_cls = e_sel;
        end
        for (int p = 0; p < NP; p++) begin
            if (cur_v[p] && e_rdy[p]) begin
                logic [FW-1:0] f;
                int t;
                f = pend[p].pop_front();
                t = e_tgt[p];
                mq[t].push_back(f);
                if (fhead(f)) pcls[p] = int'(f[0]);
                if (fhead(f) && !ftail(f)) begin lk_on[t] = 1; lk_by[t] = p; end
                else if (ftail(f)) lk_on[t] = 0;
                cur_v[p] = 0;
            end
        end
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        in_valid = '0;
        in_flit = '0;
        out_ready = 1'b0;
        for (int p = 0; p < NP; p++) begin cur_v[p] = 0; seq[p] = 0; pcls[p] = 0; end
        for (int q = 0; q < 2; q++) begin lk_on[q] = 0; lk_by[q] = 0; end
        c_on = 0; c_cls = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", "out_valid after reset", int'(out_valid), 0);
        check("R1", "gs_count after reset", int'(gs_count), 0);
        check("R1", "be_count after reset", int'(be_count), 0);

        for (int cyc = 0; cyc < NCYC; cyc++) begin
            bit gen_on;
            int rate;
            @(negedge clk);
            gen_on = (cyc < 5000);
            rate = 70;
            // Stimulus modes
            for (int p = 0; p < NP; p++) begin
                if (!cur_v[p] && pend[p].size() == 0 && gen_on) begin
                    if (cyc >= 1500 && cyc < 2500) begin
                        // long best-effort packets on port 0, sparse guaranteed on port 1
                        if (p == 0) make_pkt(p, 0, 4);
                        else if ($urandom % 100 < 20) make_pkt(p, 1, 1 + int'($urandom % 4));
                    end else begin
                        make_pkt(p, int'($urandom % 2), 1 + int'($urandom % 4));
                    end
                end
                if (!cur_v[p] && pend[p].size() > 0 && ($urandom % 100 < rate)) cur_v[p] = 1;
                in_valid[p] = cur_v[p];
                in_flit[p]  = cur_v[p] ? pend[p][0] : '0;
            end
            if (cyc >= 2500 && cyc < 3500) out_ready = ((cyc % 60) >= 40);
            else if (cyc >= 3500 && cyc < 5000) out_ready = ($urandom % 100 < 60);
            else if (cyc >= 5000) out_ready = 1'b1;
            else out_ready = ($urandom % 100 < 85);
            #1;
            model_comb();
            for (int p = 0; p < NP; p++)
                if (cur_v[p]) check("R3 R7", $sformatf("in_ready[%0d]", p), int'(in_ready[p]), int'(e_rdy[p]));
            check("R4 R8", "out_valid", int'(out_valid), int'(e_ov));
            if (e_ov) check("R2 R5 R6", "out_flit", int'(out_flit), int'(mq[e_sel][0]));
            check("R2 R3", "gs_count", int'(gs_count), mq[1].size());
            check("R2 R3", "be_count", int'(be_count), mq[0].size());
            @(posedge clk);
            model_step();
        end

        @(negedge clk);
        #1;
        check("R6", "gs_count drained", int'(gs_count), 0);
        check("R6", "be_count drained", int'(be_count), 0);
        check("R6", "out_valid drained", int'(out_valid), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule